// File: doc/BRIEF.md
# Pipeline Stage Register with Freeze and Flush

This block sits between two pipeline stages. It holds a payload that has two parts: a control part and a data part. It also keeps a flag that says whether the held entry is live. Four inputs steer it. A load strobe marks input that is ready to take, and it lets the register pass over garbage while a slow producer, such as a delayed memory response, has not yet delivered. A freeze input holds the register in place whatever the strobe says. A control-only flush squashes the control part. A full flush squashes everything.

An all-zero payload is the bubble encoding. Reset and the flushes all drive toward it, so a squashed or reset entry makes the next stage do nothing. When more than one control input is active in the same cycle, a fixed priority decides the action. The logic that decides when to stall or squash lives outside this block.

Top module: `pipe_stage_reg`

## Requirements
- R1: While reset is applied, and after it is released until the first load, `ctl_q` and `dat_q` are all zeros and `good` is 0.
- R2: With `load_vld`=1 and `freeze`, `flush_ctl` and `flush_all` all 0, the clock edge copies `ctl_in` to `ctl_q` and `dat_in` to `dat_q`, and sets `good` to 1.
- R3: With all four control inputs at 0, the edge leaves `ctl_q`, `dat_q` and `good` unchanged, whatever `ctl_in` and `dat_in` carry.
- R4: With `freeze`=1 and both flushes 0, the edge leaves every output unchanged, even when `load_vld`=1.
- R5: With `flush_all`=1, the edge clears `ctl_q` and `dat_q` to zero and `good` to 0. This holds whatever the other three control inputs are.
- R6: With `flush_ctl`=1 and `flush_all`=0, the edge clears `ctl_q` to zero and `good` to 0. `dat_q` is left unchanged, whatever `freeze` and `load_vld` are.
- R7: The fixed priority, from highest to lowest, is `flush_all`, `flush_ctl`, `freeze`, `load_vld`. When both flushes are high, both parts are cleared.
- R8: After a flush, `good` stays 0 through hold and freeze cycles until the next load under R2.
- R9: Reset is asserted asynchronously. Pulling `rst_n` low clears all outputs without waiting for a clock edge. Release takes effect two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| load_vld | input | 1 | Input payload is ready to be taken |
| freeze | input | 1 | Hold the register; overrides `load_vld` |
| flush_ctl | input | 1 | Clear the control part only |
| flush_all | input | 1 | Clear the control and data parts |
| ctl_in | input | CTL_W | Incoming control part |
| dat_in | input | DAT_W | Incoming data part |
| ctl_q | output | CTL_W | Registered control part |
| dat_q | output | DAT_W | Registered data part |
| good | output | 1 | Held entry was loaded and has not been flushed |

## Verification
The hardest cases are the ones that cannot be told apart from an empty register. A hold or freeze that wrongly acts as a clear, or a control-only flush that also wipes the data, looks the same as the bubble state. To expose these cases, every sweep vector first loads a known non-zero payload, and in half of the vectors it then also applies a control-only flush. This gives two starting states, one live and one squashed with its data still held. All sixteen combinations of the four control inputs are then applied to each starting state, and the result is compared against an arithmetic model. A long pseudo-random walk follows the sweep, and an asynchronous reset pulse is applied in the middle of a cycle.

// File: rtl/stgreg_pkg.sv
package stgreg_pkg;
  typedef enum logic [1:0] {
    FLD_HOLD = 2'd0,
    FLD_LOAD = 2'd1,
    FLD_CLR  = 2'd2
  } fld_act_e;
endpackage

// File: rtl/stgreg_rst_sync.sv
module stgreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/stgreg_ctrl.sv
module stgreg_ctrl
  import stgreg_pkg::*;
(
  input  logic     load_vld,
  input  logic     freeze,
  input  logic     flush_ctl,
  input  logic     flush_all,
  output fld_act_e ctl_act,
  output fld_act_e dat_act,
  output logic     good_set,
  output logic     good_clr
);
  always_comb begin
    ctl_act  = FLD_HOLD;
    dat_act  = FLD_HOLD;
    good_set = 1'b0;
    good_clr = 1'b0;
    if (flush_all) begin
      ctl_act  = FLD_CLR;
      dat_act  = FLD_CLR;
      good_clr = 1'b1;
    end else if (flush_ctl) begin
      ctl_act  = FLD_CLR;
      good_clr = 1'b1;
    end else if (freeze) begin
      ctl_act  = FLD_HOLD;
    end else if (load_vld) begin
      ctl_act  = FLD_LOAD;
      dat_act  = FLD_LOAD;
      good_set = 1'b1;
    end
  end
endmodule

// File: rtl/stgreg_field.sv
module stgreg_field
  import stgreg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fld_act_e     act,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = (act != FLD_HOLD);
    q_nxt = (act == FLD_LOAD) ? d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R5
  field_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == FLD_CLR |=> q == '0);

  // R3
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == FLD_HOLD |=> $stable(q));
endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg
  import stgreg_pkg::*;
#(
  parameter int CTL_W = 6,
  parameter int DAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_vld,
  input  logic             freeze,
  input  logic             flush_ctl,
  input  logic             flush_all,
  input  logic [CTL_W-1:0] ctl_in,
  input  logic [DAT_W-1:0] dat_in,
  output logic [CTL_W-1:0] ctl_q,
  output logic [DAT_W-1:0] dat_q,
  output logic             good
);
  localparam int SYNC_STAGES = 2;

  logic     rst_sync_n;
  fld_act_e ctl_act;
  fld_act_e dat_act;
  logic     good_set;
  logic     good_clr;
  logic     good_nxt;
  logic     good_en;

  stgreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stgreg_ctrl u_ctrl (
    .load_vld  (load_vld),
    .freeze    (freeze),
    .flush_ctl (flush_ctl),
    .flush_all (flush_all),
    .ctl_act   (ctl_act),
    .dat_act   (dat_act),
    .good_set  (good_set),
    .good_clr  (good_clr)
  );

  stgreg_field #(.W(CTL_W)) u_ctl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .act   (ctl_act),
    .d     (ctl_in),
    .q     (ctl_q)
  );

  stgreg_field #(.W(DAT_W)) u_dat (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .act   (dat_act),
    .d     (dat_in),
    .q     (dat_q)
  );

  always_comb begin
    good_en  = good_set | good_clr;
    good_nxt = good_set & ~good_clr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  good <= 1'b0;
    else if (good_en) good <= good_nxt;
  end

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_vld && !freeze && !flush_ctl && !flush_all
    |=> ctl_q == $past(ctl_in) && dat_q == $past(dat_in) && good);

  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    freeze && !flush_ctl && !flush_all
    |=> $stable(ctl_q) && $stable(dat_q) && $stable(good));

  // R6
  ctl_flush_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush_ctl && !flush_all |=> ctl_q == '0 && $stable(dat_q) && !good);

  // R7
  full_flush_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush_all |=> ctl_q == '0 && dat_q == '0 && !good);

  // R8
  good_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(good) |-> $past(load_vld) && !$past(freeze));
endmodule

// File: tb/sim_pipe_stage_reg.sv
module sim_pipe_stage_reg;
  localparam int CW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_vld, freeze, flush_ctl, flush_all;
  logic [CW-1:0] ctl_in;
  logic [DW-1:0] dat_in;
  logic [CW-1:0] ctl_q;
  logic [DW-1:0] dat_q;
  logic          good;

  logic [CW-1:0] ec;
  logic [DW-1:0] ed;
  logic          eg;
  int            n_chk = 0;
  int            n_bad = 0;
  logic [15:0]   lfsr = 16'hACE1;

  always #2 clk = ~clk;

  pipe_stage_reg #(.CTL_W(CW), .DAT_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .load_vld(load_vld), .freeze(freeze),
    .flush_ctl(flush_ctl), .flush_all(flush_all), .ctl_in(ctl_in),
    .dat_in(dat_in), .ctl_q(ctl_q), .dat_q(dat_q), .good(good)
  );

  task automatic check(input string req);
    n_chk++;
    if (ctl_q !== ec || dat_q !== ed || good !== eg) begin
      n_bad++;
      $display("FAIL %s: got ctl=%h dat=%h good=%b, expected ctl=%h dat=%h good=%b",
               req, ctl_q, dat_q, good, ec, ed, eg);
    end
  endtask

  // One clock: drive at negedge, update model from the requirements, compare after posedge.
  task automatic step(input logic [3:0] c, input logic [CW-1:0] ci,
                      input logic [DW-1:0] di, input string req);
    @(negedge clk);
    {flush_all, flush_ctl, freeze, load_vld} = c;
    ctl_in = ci;
    dat_in = di;
    if (c[3])      begin ec = '0; ed = '0; eg = 1'b0; end   // R5 R7
    else if (c[2]) begin ec = '0; eg = 1'b0; end            // R6
    else if (c[1]) begin end                                // R4
    else if (c[0]) begin ec = ci; ed = di; eg = 1'b1; end   // R2
    @(posedge clk);
    #1;
    check(req);
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {flush_all, flush_ctl, freeze, load_vld} = 4'b0001;
    ctl_in = 4'hF; dat_in = 8'hFF;
    ec = '0; ed = '0; eg = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 during reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check("R9 first edge after release held");
    @(negedge clk) {flush_all, flush_ctl, freeze, load_vld} = 4'b0000;
    @(posedge clk); #1 check("R1 after release");

    // R3: idle with garbage on the inputs
    step(4'b0000, 4'h9, 8'h5A, "R3 idle before load");
    step(4'b0001, 4'hA, 8'h3C, "R2 first load");
    step(4'b0000, 4'h1, 8'hEE, "R3 hold");

    // Exhaustive sweep: two prior states x sixteen control combinations
    for (int pre = 0; pre < 2; pre++) begin
      for (int c = 0; c < 16; c++) begin
        step(4'b0001, CW'(c + 3), DW'(c * 17 + 5), "R2 setup load");
        if (pre == 1) step(4'b0100, 4'h0, 8'h00, "R6 setup ctl flush");
        step(4'(c), CW'(~(c + 3)), DW'(c * 29 + 77),
             c >= 8 ? "R5 R7 full flush" :
             c >= 4 ? "R6 ctl flush" :
             c >= 2 ? "R4 freeze" :
             c == 1 ? "R2 load" : "R3 idle");
        // R8: good must not come back while holding or freezing
        step(4'b0010, 4'h7, 8'h11, "R8 freeze after step");
        step(4'b0000, 4'h6, 8'h22, "R8 hold after step");
      end
    end

    // Pseudo-random walk
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step({lfsr[3] & lfsr[7], lfsr[5] & lfsr[9], lfsr[1], lfsr[0]},
           lfsr[15:12], lfsr[11:4], "R7 random priority");
    end

    // R9: asynchronous assertion mid-cycle
    step(4'b0001, 4'hC, 8'h99, "R2 load before async reset");
    @(negedge clk);
    {flush_all, flush_ctl, freeze, load_vld} = 4'b0000;
    #0.5 rst_n = 1'b0;
    #0.5;
    ec = '0; ed = '0; eg = 1'b0;
    check("R9 async clear");
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R1 after second release");
    step(4'b0001, 4'h5, 8'hA5, "R2 load after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule